// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller for a dual-slope integrating converter. A prescaler derives a count tick from the master clock. The count tick advances a three-phase frame. Each phase drives one group of analog switch controls. In the zeroing phase the offset-cancel loop is closed. In the run-up phase the input is connected to the integrator for a fixed number of counts. In the run-down phase a reference of the opposite sign is connected until the integrator returns to zero.

The only feedback from the analog side is one comparator bit. The block samples that bit on the last run-up count to decide the sign of the input. It then watches the same bit during run-down and stops at the first count on which the bit differs from the sampled level. The number of run-down counts is the magnitude of the result. The zeroing phase is stretched or shortened by the run-down length of the previous frame. This keeps the time from the start of one run-down to the start of the next run-up constant.

Top module: `dual_slope_seq`

## Requirements
- R1: The phases always follow the cycle zeroing, run-up, run-down, zeroing. Exactly one of `az_o`, `in_o` and (`ref_pos_o` or `ref_neg_o`) is high in every cycle.
- R2: Phase counters advance only on a count tick. A count tick occurs once every `CLK_DIV` master clocks, so every phase lasts a whole number of ticks times `CLK_DIV` clocks.
- R3: The run-up phase lasts exactly `T_INT` counts, which is `T_INT*CLK_DIV` clocks of `in_o` high.
- R4: `cmp_i` is sampled on the last run-up count. A low sample gives `sign_o`=1 (negative) and a high sample gives `sign_o`=0. This holds even when the run-down magnitude is zero.
- R5: During run-down, `ref_neg_o` is high if the sampled comparator level was 1 and `ref_pos_o` is high if it was 0. Both are low outside run-down.
- R6: Run-down counts are numbered from 0. The run-down ends on the first count whose `cmp_i` sample differs from the level latched in R4, and that count's index is reported on `mag_o`.
- R7: If no difference has appeared by count `DEINT_MAX`, the run-down ends on that count with `mag_o`=`DEINT_MAX` and `ovr_o`=1. Otherwise `ovr_o`=0, including when the crossing falls exactly on count `DEINT_MAX`.
- R8: The zeroing phase lasts max(`AZ_BASE` − previous `mag_o`, `AZ_MIN`) counts. The first zeroing phase after reset lasts `AZ_BASE` counts.
- R9: `mag_o`, `sign_o` and `ovr_o` change only at the edge that ends a run-down. `valid_o` is high for exactly the one clock that follows that edge.
- R10: A synchronous active-high `rst` puts the block at the start of zeroing, with `az_o`=1, all other controls low, and `mag_o`, `sign_o`, `ovr_o`, `valid_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator: 1 when the integrator is on the positive side |
| az_o | output | 1 | Zeroing switch control |
| in_o | output | 1 | Input connect control (run-up) |
| ref_pos_o | output | 1 | Positive reference connect (run-down) |
| ref_neg_o | output | 1 | Negative reference connect (run-down) |
| mag_o | output | $clog2(DEINT_MAX+1) | Run-down count of the last frame |
| sign_o | output | 1 | 1 when the last input was negative |
| ovr_o | output | 1 | Last run-down hit the count limit |
| valid_o | output | 1 | One-clock strobe marking a new result |

## Verification
Two cases are the hardest to reach from the ports. The first is a run-down that stops exactly on count `DEINT_MAX`, which must be told apart from one that runs past it. The second is a zeroing phase that has to be clamped at its minimum. The bench's integrator model flips the comparator a stimulus-controlled number of clocks into run-down. Choosing the magnitudes `DEINT_MAX`, `DEINT_MAX+1` and larger, with a small `AZ_BASE`, drives both cases. A zero-magnitude input with a negative sign covers the sub-count polarity case.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    PH_AZ    = 3'b001,
    PH_INT   = 3'b010,
    PH_DEINT = 3'b100
  } phase_t;
endpackage

// File: rtl/dsc_prescale.sv
module dsc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt   <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (pcnt == LAST);
      pcnt   <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int T_INT     = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int AZ_MIN    = 1000,
  parameter int AZ_BASE   = 3000,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          cmp_i,
  output phase_t        phase_o,
  output logic          hold_o,
  output logic [CW-1:0] cnt_o,
  output logic          end_o,
  output logic          end_ovr_o
);
  logic [CW-1:0] az_len;
  logic [CW-1:0] az_next;
  logic          crossed;

  assign crossed   = (cmp_i != hold_o);
  assign end_o     = tick_i && (phase_o == PH_DEINT) &&
                     (crossed || cnt_o == CW'(DEINT_MAX));
  assign end_ovr_o = !crossed;

  always_comb begin
    int d;
    d = AZ_BASE - int'(cnt_o);
    az_next = (d < AZ_MIN) ? CW'(AZ_MIN) : CW'(d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= PH_AZ;
      cnt_o   <= '0;
      az_len  <= CW'(AZ_BASE);
      hold_o  <= 1'b0;
    end else if (tick_i) begin
      case (phase_o)
        PH_AZ: begin
          if (cnt_o == az_len - 1'b1) begin
            phase_o <= PH_INT;
            cnt_o   <= '0;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        PH_INT: begin
          if (cnt_o == CW'(T_INT - 1)) begin
            phase_o <= PH_DEINT;
            cnt_o   <= '0;
            hold_o  <= cmp_i;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        PH_DEINT: begin
          if (end_o) begin
            phase_o <= PH_AZ;
            cnt_o   <= '0;
            az_len  <= az_next;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        default: begin
          phase_o <= PH_AZ;
          cnt_o   <= '0;
        end
      endcase
    end
  end

  // checker counters: ticks spent in run-up and in zeroing
  logic [CW-1:0] int_seen;
  logic [CW-1:0] az_seen;
  always_ff @(posedge clk) begin
    if (rst || phase_o == PH_AZ) int_seen <= '0;
    else if (tick_i && phase_o == PH_INT) int_seen <= int_seen + 1'b1;
    if (rst || phase_o == PH_DEINT) az_seen <= '0;
    else if (tick_i && phase_o == PH_AZ) az_seen <= az_seen + 1'b1;
  end

  // R1
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);
  // R1
  az_next_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_AZ) |=> (phase_o == PH_AZ || phase_o == PH_INT));
  // R1
  int_next_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_INT) |=> (phase_o == PH_INT || phase_o == PH_DEINT));
  // R1
  deint_next_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_DEINT) |=> (phase_o == PH_DEINT || phase_o == PH_AZ));
  // R3
  int_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_o == PH_DEINT) |-> int_seen == CW'(T_INT));
  // R8
  az_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_o == PH_INT) |-> az_seen >= CW'(AZ_MIN));
  // R7
  deint_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_DEINT) |-> cnt_o <= CW'(DEINT_MAX));
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_DEINT && $past(phase_o) == PH_DEINT) |-> $stable(hold_o));
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
  parameter int DEINT_MAX = 2000,
  parameter int CW        = 12,
  parameter int MW        = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          end_i,
  input  logic          ovr_i,
  input  logic          hold_i,
  input  logic [CW-1:0] cnt_i,
  output logic [MW-1:0] mag_o,
  output logic          sign_o,
  output logic          ovr_o,
  output logic          valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_o   <= '0;
      sign_o  <= 1'b0;
      ovr_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= end_i;
      if (end_i) begin
        mag_o  <= MW'(cnt_i);
        sign_o <= !hold_i;
        ovr_o  <= ovr_i;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(mag_o) && $stable(sign_o) && $stable(ovr_o)));
  // R7
  ovr_mag_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> mag_o == MW'(DEINT_MAX));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int T_INT     = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int AZ_MIN    = 1000,
  parameter int AZ_BASE   = 3000,
  localparam int MW       = $clog2(DEINT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_i,
  output logic          az_o,
  output logic          in_o,
  output logic          ref_pos_o,
  output logic          ref_neg_o,
  output logic [MW-1:0] mag_o,
  output logic          sign_o,
  output logic          ovr_o,
  output logic          valid_o
);
  localparam int SPAN = (AZ_BASE > DEINT_MAX) ?
                        ((AZ_BASE > T_INT) ? AZ_BASE : T_INT) :
                        ((DEINT_MAX > T_INT) ? DEINT_MAX : T_INT);
  localparam int CW = $clog2(SPAN + 1);

  logic          tick;
  phase_t        phase;
  logic          hold;
  logic [CW-1:0] cnt;
  logic          end_c;
  logic          end_ovr;

  dsc_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  dsc_sequencer #(
    .T_INT(T_INT), .DEINT_MAX(DEINT_MAX), .AZ_MIN(AZ_MIN),
    .AZ_BASE(AZ_BASE), .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .cmp_i(cmp_i),
    .phase_o(phase), .hold_o(hold), .cnt_o(cnt),
    .end_o(end_c), .end_ovr_o(end_ovr)
  );

  dsc_result #(.DEINT_MAX(DEINT_MAX), .CW(CW), .MW(MW)) u_res (
    .clk(clk), .rst(rst), .end_i(end_c), .ovr_i(end_ovr),
    .hold_i(hold), .cnt_i(cnt),
    .mag_o(mag_o), .sign_o(sign_o), .ovr_o(ovr_o), .valid_o(valid_o)
  );

  assign az_o      = phase[0];
  assign in_o      = phase[1];
  assign ref_pos_o = phase[2] & ~hold;
  assign ref_neg_o = phase[2] &  hold;

  // R5
  ref_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_pos_o && ref_neg_o) && !((ref_pos_o || ref_neg_o) && (az_o || in_o)));
endmodule

// File: tb/dual_slope_seq_bench.sv
module dual_slope_seq_bench;
  localparam int DIV  = 4;
  localparam int TI   = 20;
  localparam int DMAX = 40;
  localparam int AMIN = 20;
  localparam int ABAS = 55;
  localparam int MW   = $clog2(DMAX + 1);
  localparam int NS   = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b1;
  logic az, inp, rpos, rneg, sgn, ovr, vld;
  logic [MW-1:0] mag;

  always #4 clk = ~clk;

  dual_slope_seq #(.CLK_DIV(DIV), .T_INT(TI), .DEINT_MAX(DMAX),
                   .AZ_MIN(AMIN), .AZ_BASE(ABAS)) u_dual_slope_seq (
    .clk(clk), .rst(rst), .cmp_i(cmp), .az_o(az), .in_o(inp),
    .ref_pos_o(rpos), .ref_neg_o(rneg), .mag_o(mag), .sign_o(sgn),
    .ovr_o(ovr), .valid_o(vld)
  );

  int checks = 0;
  int errors = 0;
  int s_neg[NS];
  int s_mag[NS];
  int idx = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  int m_pre, m_tq, m_ph, m_cnt, m_az, m_hold, m_mag, m_sgn, m_ovr, m_val;
  always @(posedge clk) begin
    int tq_old;
    tq_old = m_tq;
    if (rst) begin
      m_pre = 0; m_tq = 0; m_ph = 0; m_cnt = 0; m_az = ABAS;
      m_hold = 0; m_mag = 0; m_sgn = 0; m_ovr = 0; m_val = 0;
    end else begin
      m_val = 0;
      if (tq_old != 0) begin
        if (m_ph == 0) begin
          if (m_cnt == m_az - 1) begin m_ph = 1; m_cnt = 0; end
          else m_cnt++;
        end else if (m_ph == 1) begin
          if (m_cnt == TI - 1) begin m_ph = 2; m_cnt = 0; m_hold = int'(cmp); end
          else m_cnt++;
        end else begin
          if (int'(cmp) != m_hold || m_cnt == DMAX) begin
            m_mag = m_cnt;
            m_ovr = (int'(cmp) == m_hold) ? 1 : 0;
            m_sgn = (m_hold == 0) ? 1 : 0;
            m_val = 1;
            m_az  = (ABAS - m_cnt < AMIN) ? AMIN : ABAS - m_cnt;
            m_ph  = 0; m_cnt = 0;
          end else m_cnt++;
        end
      end
      m_tq  = (m_pre == DIV - 1) ? 1 : 0;
      m_pre = (m_pre + 1) % DIV;
    end
  end

  // per-clock comparison, duration checks and integrator model
  int k = 0;
  int az_clk = 0, in_clk = 0;
  int exp_az = 0;
  bit first_az = 1'b1;
  always @(negedge clk) begin
    int cur;
    chk("R1 az_o",      int'(az),   (m_ph == 0) ? 1 : 0);
    chk("R1 in_o",      int'(inp),  (m_ph == 1) ? 1 : 0);
    chk("R5 ref_pos_o", int'(rpos), (m_ph == 2 && m_hold == 0) ? 1 : 0);
    chk("R5 ref_neg_o", int'(rneg), (m_ph == 2 && m_hold == 1) ? 1 : 0);
    chk("R6 mag_o",     int'(mag),  m_mag);
    chk("R4 sign_o",    int'(sgn),  m_sgn);
    chk("R7 ovr_o",     int'(ovr),  m_ovr);
    chk("R9 valid_o",   int'(vld),  m_val);
    if (!rst) begin
      cur = (idx < NS) ? idx : NS - 1;
      // R2 R3: run-up length in clocks
      if (inp) in_clk++;
      else if (in_clk > 0) begin chk("R3 run-up clocks", in_clk, TI * DIV); in_clk = 0; end
      // R8: zeroing length in clocks
      if (az) az_clk++;
      else if (az_clk > 0) begin
        if (!first_az) chk("R8 zeroing clocks", az_clk, exp_az * DIV);
        first_az = 1'b0;
        az_clk = 0;
      end
      if (vld && idx < NS) begin
        chk("R6 frame magnitude", int'(mag), (s_mag[idx] > DMAX) ? DMAX : s_mag[idx]);
        chk("R4 frame sign",      int'(sgn), s_neg[idx]);
        chk("R7 frame over-range", int'(ovr), (s_mag[idx] > DMAX) ? 1 : 0);
        exp_az = ABAS - int'(mag);
        if (exp_az < AMIN) exp_az = AMIN;
        idx++;
        cur = (idx < NS) ? idx : NS - 1;
      end
      if (rpos || rneg) begin
        cmp = (k >= 4 * s_mag[cur]) ? (s_neg[cur] != 0) : (s_neg[cur] == 0);
        k++;
      end else begin
        cmp = (s_neg[cur] == 0);
        k = 0;
      end
    end
  end

  initial begin
    s_neg[0] = 0; s_mag[0] = 5;
    s_neg[1] = 1; s_mag[1] = 7;
    s_neg[2] = 1; s_mag[2] = 0;    // R4 sub-count negative
    s_neg[3] = 0; s_mag[3] = 0;
    s_neg[4] = 0; s_mag[4] = 40;   // R7 crossing on the last count
    s_neg[5] = 0; s_mag[5] = 41;   // R7 over-range
    s_neg[6] = 1; s_mag[6] = 60;   // R7 over-range, negative
    s_neg[7] = 0; s_mag[7] = 1;
    s_neg[8] = 1; s_mag[8] = 39;   // R8 clamp at minimum follows
    s_neg[9] = 0; s_mag[9] = 25;
    s_neg[10] = 1; s_mag[10] = 3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fork
      begin
        wait (idx == NS);
      end
      begin
        repeat (100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d frames", idx, NS);
      end
    join_any
    disable fork;
    // R10: reset in the middle of a frame
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 az_o",    int'(az),   1);
    chk("R10 in_o",    int'(inp),  0);
    chk("R10 ref",     int'(rpos | rneg), 0);
    chk("R10 mag_o",   int'(mag),  0);
    chk("R10 sign_o",  int'(sgn),  0);
    chk("R10 ovr_o",   int'(ovr),  0);
    chk("R10 valid_o", int'(vld),  0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule